// File: doc/BRIEF.md
# Four-Rail Soft-Start and Hiccup Supervisor

This block is the digital supervisor for four voltage regulators. Channel 0 is a switching rail guarded by an overcurrent comparator. Channels 1 to 3 are linear rails, each guarded by an undervoltage comparator. Each channel has a disable input. A single power-good input comes from an external bias-supply comparator. The comparators, error amplifiers, modulator, gate drivers and reference DAC all sit outside the block and talk to it through synchronous digital signals.

For each channel the block drives three outputs: an enable, an 8-bit reference code that the DAC turns into the soft-start reference, and a fault flag. A channel starts once power-good is high and its disable is low. Its reference then ramps from zero to full scale over one fixed soft-start interval and holds there.

A sustained fault shuts down only the channel that has it. That channel sits out three whole intervals with its reference at zero, then ramps again in the fourth. The interval length and the undervoltage filter length are both derived from a clock-frequency parameter.

Top module: `rail_softstart_seq`

## Requirements
- R1: While rst_n is low, and one cycle after any edge that samples pg low, every enable, every reference code and every fault flag is zero. Each channel's hiccup wait count is cleared at that point, so a channel that was in a hiccup wait ramps afresh as soon as pg returns.
- R2: A channel in the off state moves to ramping on the first edge that samples pg high and its dis bit low. Its enable goes high with a code of 0. The code then rises by exactly 1 per step until it reaches 255, and holds at 255 while the channel runs.
- R3: One step lasts STEP = max(1, (CLK_KHZ*SS_US/1000)/256) clock cycles, so one soft-start interval is 256 steps. With STEP = 1, the code reads n-1 after n edges of ramping.
- R4: While channel 0 is enabled, a high oc sampled at an edge shuts channel 0 down on that same edge. After the edge its enable is 0, its code is 0 and its fault flag is 1.
- R5: The uv input of a linear channel (uv bit k belongs to channel k+1) counts as a fault only once it has been high on DG = max(1, CLK_KHZ*DG_NS/1000000) consecutive edges. A shorter pulse leaves the channel running with its fault flag clear.
- R6: While a linear channel's ramp code is below 64 (one quarter of full scale), its filtered undervoltage is ignored. From code 64 onward, and while the channel runs, the filtered undervoltage shuts it down.
- R7: A fault, disable or restart on one channel leaves the enable, code and fault flag of every other channel unchanged.
- R8: After a fault shutdown, the channel keeps its enable low, its code at 0 and its fault flag at 1 for exactly 768 steps. It then re-enters ramping from code 0 with its fault flag cleared.
- R9: A fault during a restart ramp starts the full 768-step wait over again.
- R10: While a channel's dis bit is high, that channel is held off: enable 0, code 0, fault flag 0. After dis falls, the channel begins a fresh ramp from code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pg | input | 1 | Bias-supply power-good |
| dis | input | 4 | Per-channel disable, bit i = channel i |
| oc | input | 1 | Overcurrent detect for channel 0 |
| uv | input | 3 | Undervoltage detect, bit k = channel k+1 |
| en | output | 4 | Per-channel regulator enable |
| ref_code | output | 32 | Reference codes, bits [8i+7:8i] = channel i |
| flt | output | 4 | Per-channel fault flag (set during hiccup wait) |

## Verification
The hardest case to reach from the ports is a fault that arrives during a restart ramp. Reaching it needs a first fault, then the exact 768-step wait, then a second fault timed inside the new ramp. The bench runs the ramp at one step per clock, trips channel 0 with a one-cycle oc pulse, and samples the enable on the last waiting cycle and on the first ramping cycle. It then trips the channel again in that first ramping cycle and confirms that the full wait repeats. Undervoltage blanking is reached by raising uv in the same cycle as pg, so the filter saturates while the code is still below a quarter of full scale.

// File: rtl/rail_softstart_seq.sv
module rail_softstart_seq #(
  parameter int CLK_KHZ = 25000,
  parameter int SS_US   = 6830,
  parameter int DG_NS   = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pg,
  input  logic [3:0]  dis,
  input  logic        oc,
  input  logic [2:0]  uv,
  output logic [3:0]  en,
  output logic [31:0] ref_code,
  output logic [3:0]  flt
);
  localparam int SS_CYC   = CLK_KHZ * SS_US / 1000;
  localparam int STEP_RAW = SS_CYC / 256;
  localparam int STEP     = (STEP_RAW < 1) ? 1 : STEP_RAW;
  localparam int PW       = (STEP > 1) ? $clog2(STEP) : 1;
  localparam int DG_RAW   = CLK_KHZ * DG_NS / 1000000;
  localparam int DG       = (DG_RAW < 1) ? 1 : DG_RAW;
  localparam int DGW      = (DG > 1) ? $clog2(DG) : 1;

  typedef enum logic [1:0] {S_OFF, S_RAMP, S_RUN, S_WAIT} st_t;

  for (genvar i = 0; i < 4; i++) begin : g_ch
    st_t           st;
    logic [7:0]    cnt;
    logic [1:0]    lap;
    logic [PW-1:0] pre;
    logic          fl;
    logic          trip;
    logic          tick;

    assign tick = (pre == PW'(STEP - 1));

    if (i == 0) begin : g_sw
      assign trip = oc;
    end else begin : g_lin
      logic [DGW-1:0] dg;
      logic           uvf;
      assign uvf  = uv[i-1] && (dg == DGW'(DG - 1));
      assign trip = uvf && (cnt[7:6] != 2'b00);
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                   dg <= '0;
        else if (!uv[i-1])            dg <= '0;
        else if (dg != DGW'(DG - 1))  dg <= dg + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st <= S_OFF; cnt <= '0; lap <= '0; pre <= '0; fl <= 1'b0;
      end else if (!pg || dis[i]) begin
        st <= S_OFF; cnt <= '0; lap <= '0; pre <= '0; fl <= 1'b0;
      end else begin
        case (st)
          S_OFF: begin
            st <= S_RAMP; cnt <= '0; pre <= '0;
          end
          S_RAMP, S_RUN: begin
            if (trip) begin
              st <= S_WAIT; cnt <= '0; lap <= '0; pre <= '0; fl <= 1'b1;
            end else if (st == S_RAMP) begin
              pre <= tick ? '0 : pre + 1'b1;
              if (tick) begin
                if (cnt == 8'hFF) st <= S_RUN;
                else              cnt <= cnt + 1'b1;
              end
            end
          end
          default: begin
            pre <= tick ? '0 : pre + 1'b1;
            if (tick) begin
              cnt <= cnt + 1'b1;
              if (cnt == 8'hFF) begin
                if (lap == 2'd2) begin
                  st <= S_RAMP; fl <= 1'b0; lap <= '0;
                end else begin
                  lap <= lap + 1'b1;
                end
              end
            end
          end
        endcase
      end
    end

    assign en[i]            = (st == S_RAMP) || (st == S_RUN);
    assign ref_code[i*8+:8] = en[i] ? cnt : 8'h00;
    assign flt[i]           = fl;
  end
endmodule

// File: rtl/rail_softstart_seq_chk.sv
module rail_softstart_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pg,
  input logic [3:0]  dis,
  input logic        oc,
  input logic [3:0]  en,
  input logic [31:0] ref_code,
  input logic [3:0]  flt
);
  a_r1_pg_low_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pg |=> (en == 4'h0 && ref_code == 32'h0 && flt == 4'h0));

  a_r4_oc_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (pg && !dis[0] && en[0] && oc) |=> (!en[0] && flt[0] && ref_code[7:0] == 8'h00));

  for (genvar i = 0; i < 4; i++) begin : g_c
    a_r8_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      flt[i] |-> (!en[i] && ref_code[i*8+:8] == 8'h00));

    a_r2_ramp_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en[i]) |-> ref_code[i*8+:8] == 8'h00);

    a_r2_ref_climb: assert property (@(posedge clk) disable iff (!rst_n)
      (en[i] && $past(en[i])) |->
        (ref_code[i*8+:8] == $past(ref_code[i*8+:8]) ||
         ref_code[i*8+:8] == $past(ref_code[i*8+:8]) + 8'd1));

    a_r10_dis_off: assert property (@(posedge clk) disable iff (!rst_n)
      dis[i] |=> (!en[i] && !flt[i]));
  end
endmodule

bind rail_softstart_seq rail_softstart_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pg(pg), .dis(dis), .oc(oc),
  .en(en), .ref_code(ref_code), .flt(flt)
);

// File: tb/rail_softstart_seq_tb.sv
module rail_softstart_seq_tb;
  localparam int CLK_PERIOD = 10;
  // Vector fields: pg | dis[4] | oc | uv[3] | cycles[12] | exp_en[4] | exp_flt[4]
  localparam int NV = 13;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 4'b0000, 1'b0, 3'b000, 12'd10,  4'b0000, 4'b0000}, // R1 pg low
    {1'b1, 4'b0000, 1'b0, 3'b000, 12'd300, 4'b1111, 4'b0000}, // R2 all run
    {1'b1, 4'b0000, 1'b0, 3'b001, 12'd3,   4'b1111, 4'b0000}, // R5 short uv
    {1'b1, 4'b0000, 1'b0, 3'b000, 12'd10,  4'b1111, 4'b0000}, // R5
    {1'b1, 4'b0000, 1'b0, 3'b001, 12'd4,   4'b1101, 4'b0010}, // R5 trip, R7
    {1'b1, 4'b0000, 1'b0, 3'b000, 12'd700, 4'b1101, 4'b0010}, // R8 waiting
    {1'b1, 4'b0000, 1'b0, 3'b000, 12'd100, 4'b1111, 4'b0000}, // R8 restarted
    {1'b1, 4'b0000, 1'b0, 3'b000, 12'd300, 4'b1111, 4'b0000},
    {1'b1, 4'b0000, 1'b1, 3'b000, 12'd1,   4'b1110, 4'b0001}, // R4, R7
    {1'b1, 4'b1000, 1'b0, 3'b000, 12'd5,   4'b0110, 4'b0001}, // R10
    {1'b1, 4'b0000, 1'b0, 3'b000, 12'd300, 4'b1110, 4'b0001}, // R10 release
    {1'b0, 4'b0000, 1'b0, 3'b000, 12'd3,   4'b0000, 4'b0000}, // R1 drop
    {1'b1, 4'b0000, 1'b0, 3'b000, 12'd300, 4'b1111, 4'b0000}  // R1 return
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pg = 1'b0;
  logic [3:0]  dis = '0;
  logic        oc = 1'b0;
  logic [2:0]  uv = '0;
  logic [3:0]  en;
  logic [31:0] ref_code;
  logic [3:0]  flt;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rail_softstart_seq #(.CLK_KHZ(4000), .SS_US(64), .DG_NS(1000)) u_dut (
    .clk(clk), .rst_n(rst_n), .pg(pg), .dis(dis), .oc(oc), .uv(uv),
    .en(en), .ref_code(ref_code), .flt(flt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart();
    rst_n = 1'b0; pg = 1'b0; dis = '0; oc = 1'b0; uv = '0;
    cycles(2);
    rst_n = 1'b1;
  endtask

  initial begin
    cycles(1);
    chk("R1 reset en", {28'h0, en}, 32'h0);
    chk("R1 reset ref", ref_code, 32'h0);
    chk("R1 reset flt", {28'h0, flt}, 32'h0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      pg  = VEC[v][28];
      dis = VEC[v][27:24];
      oc  = VEC[v][23];
      uv  = VEC[v][22:20];
      cycles(int'(VEC[v][19:8]));
      chk($sformatf("R1-vec%0d en", v),  {28'h0, en},  {28'h0, VEC[v][7:4]});
      chk($sformatf("R1-vec%0d flt", v), {28'h0, flt}, {28'h0, VEC[v][3:0]});
    end

    // R2, R3: ramp code timing
    restart(); pg = 1'b1;
    cycles(100);
    chk("R3 code after 100", {24'h0, ref_code[7:0]}, 32'd99);
    chk("R3 code ch3", {24'h0, ref_code[31:24]}, 32'd99);
    cycles(156);
    chk("R2 full scale", ref_code, 32'hFFFF_FFFF);
    cycles(20);
    chk("R2 hold full", ref_code, 32'hFFFF_FFFF);

    // R6: uv during first quarter ignored
    restart(); pg = 1'b1; uv = 3'b010;
    cycles(40);
    uv = 3'b000;
    cycles(300);
    chk("R6 blanked en", {28'h0, en}, 32'hF);
    chk("R6 blanked flt", {28'h0, flt}, 32'h0);
    restart(); pg = 1'b1; uv = 3'b010;
    cycles(80);
    chk("R6 after quarter en", {28'h0, en}, 32'hB);
    chk("R6 after quarter flt", {28'h0, flt}, 32'h4);
    uv = 3'b000;

    // R8, R9: hiccup timing and fault during restart ramp
    restart(); pg = 1'b1;
    cycles(300);
    oc = 1'b1; cycles(1); oc = 1'b0;
    cycles(767);
    chk("R8 last wait en", {31'h0, en[0]}, 32'd0);
    chk("R8 last wait flt", {31'h0, flt[0]}, 32'd1);
    chk("R8 wait ref", {24'h0, ref_code[7:0]}, 32'd0);
    cycles(1);
    chk("R8 restart en", {31'h0, en[0]}, 32'd1);
    chk("R8 restart flt", {31'h0, flt[0]}, 32'd0);
    chk("R8 restart ref", {24'h0, ref_code[7:0]}, 32'd0);
    chk("R7 others run", ref_code[31:8], 32'h00FF_FFFF);
    oc = 1'b1; cycles(1); oc = 1'b0;
    chk("R9 retrip", {31'h0, en[0]}, 32'd0);
    cycles(767);
    chk("R9 full wait en", {31'h0, en[0]}, 32'd0);
    cycles(1);
    chk("R9 restart en", {31'h0, en[0]}, 32'd1);
    cycles(32);
    chk("R9 ramp code", {24'h0, ref_code[7:0]}, 32'd32);

    // R10: disable then fresh ramp
    restart(); pg = 1'b1;
    cycles(300);
    dis = 4'b0100;
    cycles(2);
    chk("R10 held off", {31'h0, en[2]}, 32'd0);
    chk("R10 ref zero", {24'h0, ref_code[23:16]}, 32'd0);
    dis = 4'b0000;
    cycles(11);
    chk("R10 fresh ramp", {24'h0, ref_code[23:16]}, 32'd10);
    chk("R7 neighbours", {ref_code[31:24], ref_code[15:0]}, 32'h00FF_FFFF);

    // R1: pg loss clears hiccup count
    restart(); pg = 1'b1;
    cycles(300);
    oc = 1'b1; cycles(1); oc = 1'b0;
    cycles(300);
    pg = 1'b0;
    cycles(2);
    chk("R1 drop flt", {28'h0, flt}, 32'h0);
    pg = 1'b1;
    cycles(300);
    chk("R1 no wait after pg", {28'h0, en}, 32'hF);
    chk("R1 full after pg", {24'h0, ref_code[7:0]}, 32'hFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule